// File: doc/BRIEF.md
# Task-Level Differential Vector Predictor

This block guesses how the memory footprint of the next task instance will differ from that of the task before it. Each time a task instance finishes, the host presents the task's ordered address set together with its differential vector: the element-by-element difference between this address set and the previous one. An internal dictionary maps each distinct differential vector to a short identifier. The identifiers of the most recent completed tasks are concatenated into a history word, and that word indexes a direct-mapped pattern table. Each table entry records which vector followed that history the last time it was seen.

When a new task starts, the block reads the table once, using the current history. If the entry is valid, the block takes the recorded vector from the dictionary, adds each of its elements to the matching element of the last completed task's address set, and streams out one prefetch address per cycle. If the entry is not valid, the block reports a miss and streams nothing. The block works best on workloads whose whole vectors recur periodically, for example two identical vectors followed by a different one.

Top module: `taskvec_predictor`

## Requirements
- R1: After reset, `pred_done` and `pf_valid` are low, no pattern-table entry is valid, and the first `task_start` reports a miss.
- R2: A `task_start` whose history selects an invalid table entry produces `pred_done` with `pred_hit` low, and `pf_valid` stays low until the next `task_start`.
- R3: A `task_start` whose history selects a valid entry produces `pred_done` with `pred_hit` high. In the same cycle, `pf_valid` rises and stays high for exactly NELEM consecutive cycles.
- R4: The k-th streamed address, with k running 0 to NELEM-1 and given on `pf_idx`, equals element k of the last completed address set plus element k of the predicted vector, sign-extended to AW bits. Element k occupies bits [k*AW +: AW] of `done_addrs` and bits [k*DW +: DW] of `done_diff`.
- R5: A completed vector equal to a stored dictionary vector reuses that entry's identifier. A vector not yet stored takes the slot named by a round-robin pointer, which starts at 0 and wraps after DICT allocations, so the (DICT+1)-th distinct vector replaces slot 0. A prediction reads the dictionary contents present at `task_start`.
- R6: On `done_valid`, the table entry selected by the current history is written with the completed vector's identifier and marked valid. The history then shifts left by one identifier, and the new identifier enters at the low end. The history holds the last HLEN identifiers and is all zero after reset.
- R7: Under a periodic pattern of whole vectors, such as A A B repeated, every task start after the training period is a hit whose addresses match the next vector in the pattern.
- R8: `pred_done` is a one-cycle pulse that appears in the cycle after each `task_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| task_start | input | 1 | One-cycle strobe: a new task instance begins |
| done_valid | input | 1 | One-cycle strobe: a task instance completed |
| done_addrs | input | NELEM*AW | Ordered address set of the completed task |
| done_diff | input | NELEM*DW | Signed differential vector of the completed task |
| pred_done | output | 1 | Lookup result is valid this cycle |
| pred_hit | output | 1 | Lookup found a valid table entry |
| pf_valid | output | 1 | Prefetch address is valid |
| pf_idx | output | $clog2(NELEM) | Element position of the current prefetch address |
| pf_addr | output | AW | Predicted prefetch address |

## Verification
The checker assumes that `task_start` and `done_valid` never occur in the same cycle. It also assumes that neither strobe arrives while an address stream is running, and that two `task_start` strobes are never back to back. These assumptions are what allow it to require a single `pred_done` pulse and an uninterrupted run of exactly NELEM stream cycles. The bench keeps within them by driving each task as a fixed sequence. It asserts start, waits out the lookup and the whole stream, and only then presents the completion, with idle cycles between strobes.

// File: rtl/taskvec_predictor.sv
module taskvec_predictor #(
  parameter int NELEM = 4,
  parameter int AW    = 32,
  parameter int DW    = 16,
  parameter int DICT  = 8,
  parameter int HLEN  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  task_start,
  input  logic                  done_valid,
  input  logic [NELEM*AW-1:0]   done_addrs,
  input  logic [NELEM*DW-1:0]   done_diff,
  output logic                  pred_done,
  output logic                  pred_hit,
  output logic                  pf_valid,
  output logic [$clog2(NELEM)-1:0] pf_idx,
  output logic [AW-1:0]         pf_addr
);
  localparam int IDW    = $clog2(DICT);
  localparam int HW     = IDW * HLEN;
  localparam int TDEPTH = 1 << HW;
  localparam int EW     = $clog2(NELEM);

  logic [NELEM*DW-1:0] dvec [DICT];
  logic [DICT-1:0]     dval;
  logic [IDW-1:0]      rr;
  logic [NELEM*AW-1:0] prev;
  logic [TDEPTH-1:0]   tval;
  logic [IDW-1:0]      tid [TDEPTH];
  logic [HW-1:0]       hist;
  logic                busy;
  logic [EW-1:0]       idx;
  logic [IDW-1:0]      pid;

  logic                mfound;
  logic [IDW-1:0]      mid;
  logic [IDW-1:0]      new_id;
  logic [DW-1:0]       sel_diff;
  logic [AW-1:0]       sel_prev;

  always_comb begin
    mfound = 1'b0;
    mid    = '0;
    for (int d = DICT - 1; d >= 0; d--) begin
      if (dval[d] && dvec[d] == done_diff) begin
        mfound = 1'b1;
        mid    = IDW'(d);
      end
    end
  end

  assign new_id   = mfound ? mid : rr;
  assign sel_diff = dvec[pid][int'(idx)*DW +: DW];
  assign sel_prev = prev[int'(idx)*AW +: AW];
  assign pf_addr  = sel_prev + {{(AW-DW){sel_diff[DW-1]}}, sel_diff};
  assign pf_valid = busy;
  assign pf_idx   = idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dval      <= '0;
      rr        <= '0;
      prev      <= '0;
      tval      <= '0;
      hist      <= '0;
      busy      <= 1'b0;
      idx       <= '0;
      pid       <= '0;
      pred_done <= 1'b0;
      pred_hit  <= 1'b0;
    end else begin
      pred_done <= task_start;
      if (task_start) begin
        pred_hit <= tval[hist];
        busy     <= tval[hist];
        pid      <= tid[hist];
        idx      <= '0;
      end else if (busy) begin
        if (idx == EW'(NELEM - 1)) busy <= 1'b0;
        else idx <= idx + 1'b1;
      end
      if (done_valid) begin
        tval[hist] <= 1'b1;
        hist       <= HW'({hist, new_id});
        prev       <= done_addrs;
        if (!mfound) begin
          dval[rr] <= 1'b1;
          rr       <= (rr == IDW'(DICT - 1)) ? '0 : rr + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (done_valid) begin
      tid[hist] <= new_id;
      if (!mfound) dvec[rr] <= done_diff;
    end
  end
endmodule

// File: rtl/taskvec_predictor_chk.sv
module taskvec_predictor_chk #(
  parameter int NELEM = 4
) (
  input logic clk,
  input logic rst_n,
  input logic task_start,
  input logic pred_done,
  input logic pred_hit,
  input logic pf_valid
);
  logic [$clog2(NELEM+1):0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else if (pf_valid) run <= run + 1'b1;
    else run <= '0;
  end

  a_r8_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    task_start |=> pred_done);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    pred_done |=> !pred_done);
  a_r2_miss_no_stream: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_done && !pred_hit) |-> !pf_valid);
  a_r3_hit_streams: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_done && pred_hit) |-> pf_valid);
  a_r3_stream_begins_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> (pred_done && pred_hit));
  a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (run < NELEM));
  a_r3_full_run: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pf_valid) |-> (run == NELEM));
endmodule

bind taskvec_predictor taskvec_predictor_chk #(.NELEM(NELEM)) u_chk (
  .clk(clk), .rst_n(rst_n), .task_start(task_start),
  .pred_done(pred_done), .pred_hit(pred_hit), .pf_valid(pf_valid)
);

// File: tb/sim_taskvec_predictor.sv
`timescale 1ns/1ps
module sim_taskvec_predictor;
  localparam int NE = 4, AW = 32, DW = 16, DICT = 8, HLEN = 3;
  localparam int IDW = 3, HW = 9, TD = 512;

  logic clk = 0, rst_n = 0, task_start = 0, done_valid = 0;
  logic [NE*AW-1:0] done_addrs = '0;
  logic [NE*DW-1:0] done_diff = '0;
  logic pred_done, pred_hit, pf_valid;
  logic [1:0] pf_idx;
  logic [AW-1:0] pf_addr;

  int total = 0, bad = 0;

  logic [NE*DW-1:0] mdict [DICT];
  bit   mval [DICT];
  int   mrr, mhist;
  int   mtbl [TD];
  bit   mtv [TD];
  logic [NE*AW-1:0] mprev;

  taskvec_predictor #(.NELEM(NE), .AW(AW), .DW(DW), .DICT(DICT), .HLEN(HLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .task_start(task_start), .done_valid(done_valid),
    .done_addrs(done_addrs), .done_diff(done_diff), .pred_done(pred_done),
    .pred_hit(pred_hit), .pf_valid(pf_valid), .pf_idx(pf_idx), .pf_addr(pf_addr));

  always #2 clk = ~clk;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NE*DW-1:0] vec_of(int k);
    logic [NE*DW-1:0] v;
    for (int i = 0; i < NE; i++) v[i*DW +: DW] = DW'(k * 40 - i * 300 + 8);
    return v;
  endfunction

  function automatic logic [AW-1:0] sext(logic [DW-1:0] d);
    return {{(AW-DW){d[DW-1]}}, d};
  endfunction

  task automatic do_start(string req);
    bit eh;
    logic [NE*DW-1:0] pv;
    eh = mtv[mhist];
    pv = eh ? mdict[mtbl[mhist]] : '0;
    @(negedge clk) task_start = 1;
    @(negedge clk) task_start = 0;
    chk(pred_done == 1, "R8", "pred_done after start", pred_done, 1);
    chk(pred_hit == eh, req, "hit flag", pred_hit, eh);
    if (eh) begin
      for (int i = 0; i < NE; i++) begin
        logic [AW-1:0] ea;
        ea = mprev[i*AW +: AW] + sext(pv[i*DW +: DW]);
        chk(pf_valid == 1, "R3", "stream valid", pf_valid, 1);
        chk(pf_idx == 2'(i), "R4", "element index", pf_idx, i);
        chk(pf_addr == ea, "R4", "prefetch address", pf_addr, ea);
        @(negedge clk);
        if (i == 0) chk(pred_done == 0, "R8", "pulse width", pred_done, 0);
      end
      chk(pf_valid == 0, "R3", "stream length", pf_valid, 0);
    end else begin
      chk(pf_valid == 0, "R2", "no stream on miss", pf_valid, 0);
      @(negedge clk);
      chk(pf_valid == 0, "R2", "no stream after miss", pf_valid, 0);
      chk(pred_done == 0, "R8", "pulse width", pred_done, 0);
    end
  endtask

  task automatic do_done(int k);
    logic [NE*DW-1:0] v;
    logic [NE*AW-1:0] a;
    int id;
    v = vec_of(k);
    for (int i = 0; i < NE; i++) a[i*AW +: AW] = mprev[i*AW +: AW] + sext(v[i*DW +: DW]) + AW'(k * 64);
    @(negedge clk) begin done_valid = 1; done_diff = v; done_addrs = a; end
    @(negedge clk) done_valid = 0;
    id = -1;
    for (int d = DICT - 1; d >= 0; d--) if (mval[d] && mdict[d] == v) id = d;
    if (id < 0) begin
      id = mrr; mdict[mrr] = v; mval[mrr] = 1; mrr = (mrr + 1) % DICT;
    end
    mtbl[mhist] = id; mtv[mhist] = 1;
    mhist = ((mhist << IDW) | id) & (TD - 1);
    mprev = a;
    @(negedge clk);
  endtask

  task automatic run_task(int k, string req);
    do_start(req);
    do_done(k);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    for (int d = 0; d < DICT; d++) mval[d] = 0;
    for (int t = 0; t < TD; t++) begin mtv[t] = 0; mtbl[t] = 0; end
    mrr = 0; mhist = 0; mprev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pred_done == 0, "R1", "reset pred_done", pred_done, 0);
    chk(pf_valid == 0, "R1", "reset pf_valid", pf_valid, 0);
    do_start("R1");
    do_done(0);
    for (int n = 0; n < 14; n++) run_task((n % 3 == 2) ? 1 : 0, (n > 8) ? "R7" : "R6");
    for (int n = 0; n < 10; n++) run_task(2 + (n % 2), "R6");
    for (int n = 0; n < 11; n++) run_task(4 + n, "R5");
    for (int n = 0; n < 14; n++) run_task((n % 3 == 2) ? 1 : 0, (n > 8) ? "R7" : "R5");
    seed = 7;
    for (int n = 0; n < 40; n++) begin
      seed = (seed * 1103 + 13) % 4093;
      run_task(seed % 5, "R6");
    end
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    for (int t = 0; t < TD; t++) mtv[t] = 0;
    for (int d = 0; d < DICT; d++) mval[d] = 0;
    mrr = 0; mhist = 0; mprev = '0;
    @(negedge clk);
    chk(pf_valid == 0, "R1", "second reset pf_valid", pf_valid, 0);
    do_start("R1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule